// File: doc/BRIEF.md
# Cycle-Steal Display Memory Arbiter

This block lets a host processor and a display refresh path share one single-port display memory without any dynamic arbitration. The oscillator clock is divided into a fixed two-clock basic cycle: the first clock of every pair is the host slot and the second is the fetch slot. While the display period is active, each fetch slot reads the word at the address given by the timing generator and presents it one clock later with a valid strobe. A host access that arrives in that period is latched, carried out in the next free host slot, and the host is held off with an active-low wait line. The wait line is released only on a rising edge of the host's own clock, which is brought into the oscillator domain through a two-flop synchronizer.

When the display period is inactive (horizontal blanking), no fetch slots are used. A host access is then served in the first clock after it is seen, and the wait line is never driven low, so the host runs at full speed. The memory itself is inside the block and is written so that it maps to a block RAM. Address decoding and the generation of the panel timing live outside.

Top module: `cyclesteal_vram_arb`

## Requirements
- R1: During and directly after reset, `host_wait_n` is 1, `fetch_valid` is 0, `host_rdata` is 0 and `slot_is_host` is 1.
- R2: `slot_is_host` inverts on every clock edge outside reset, so host slots and fetch slots strictly alternate, starting with a host slot.
- R3: While `disp_active` is 1, every fetch slot reads the word at `fetch_addr`; `fetch_valid` is 1 in the following cycle with that word on `fetch_data`, so it pulses on every second cycle.
- R4: A host request (`host_cs_n`=0 together with `host_rd_n`=0 or `host_wr_n`=0) sampled while idle and while `disp_active` is 1 drives `host_wait_n` to 0 from the next cycle.
- R5: A latched host access is executed only in a cycle that is not a fetch slot with `disp_active`=1, so it never disturbs the fetched data; a write stores `host_wdata` at `host_addr`, a read returns that location.
- R6: A stalled host is released only after its access is complete and a rising edge of `hclk` has been seen: `host_wait_n` returns to 1 at the third clock edge after `hclk` rises, and never before.
- R7: A host request accepted while `disp_active` is 0 completes without `host_wait_n` ever going low; its read data is on `host_rdata` three clock edges after the request is first sampled.
- R8: `host_rdata` changes only when a read completes and is stable from the capture through the release of the wait line until the next read completes; writes leave it unchanged.
- R9: Once a request has completed, a strobe that stays asserted is not accepted again; a new request is taken only after the strobe has been inactive at one clock edge.
- R10: While `disp_active` is 0, `fetch_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hclk | input | 1 | Host clock, asynchronous to `clk`, used only to time the wait release |
| host_cs_n | input | 1 | Host chip select for the memory, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low (wins if both strobes are low) |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| host_wait_n | output | 1 | Registered wait to the host, active low |
| disp_active | input | 1 | High during the display period when fetches are needed |
| fetch_addr | input | ADDR_W | Word address of the next display fetch |
| fetch_valid | output | 1 | High for one cycle when `fetch_data` holds a fetched word |
| fetch_data | output | DATA_W | Fetched display word |
| slot_is_host | output | 1 | 1 in a host slot, 0 in a fetch slot |

## Verification
The bench drives every input on the falling clock edge and reads outputs on the next falling edge, so each result is sampled in the cycle its register has just loaded. The wait line falls one edge after the strobe is first sampled, blanking reads land on `host_rdata` at the third edge, a fetch result appears one edge after its fetch slot, and release comes at the third edge after `hclk` rises, so the bench checks the wait line is still low after the first and second of those edges and high after the third. Because a display-time access can take two or three edges depending on the slot phase at request time, the bench waits well past the later of the two before it compares the read data, while it checks the fetch data on every valid pulse over that window.

// File: rtl/csva_pkg.sv
package csva_pkg;

  // Host request handling states
  typedef enum logic [2:0] {
    H_IDLE,  // waiting for a strobe
    H_PEND,  // request latched, waiting for a free slot
    H_CAPT,  // memory read data now on the RAM output
    H_HOLD,  // stalled host, waiting for a host clock rising edge
    H_DONE   // finished, waiting for the strobe to go away
  } host_st_e;

endpackage

// File: rtl/csva_slot_timer.sv
module csva_slot_timer (
  input  logic clk,
  input  logic rst,
  output logic slot_is_host
);

  logic phase;  // 0: host slot, 1: fetch slot

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  assign slot_is_host = ~phase;

endmodule

// File: rtl/csva_edge_sync.sv
module csva_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;

endmodule

// File: rtl/csva_spram.sv
module csva_spram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= din;
      dout <= mem[addr];
    end
  end

endmodule

// File: rtl/csva_host_ctrl.sv
module csva_host_ctrl
  import csva_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          disp_active,
  input  logic          fetch_slot,
  input  logic          hs_rise,
  input  logic [DW-1:0] ram_q,
  output logic          acc_go,
  output logic          acc_we,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  output logic          wait_n,
  output logic [DW-1:0] rdata
);

  host_st_e      st;
  logic          strobe;
  logic          lat_we;
  logic          lat_stall;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;

  assign strobe    = ~cs_n & (~rd_n | ~wr_n);
  assign acc_go    = (st == H_PEND) & ~fetch_slot;
  assign acc_we    = lat_we;
  assign acc_addr  = lat_addr;
  assign acc_wdata = lat_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= H_IDLE;
      wait_n    <= 1'b1;
      rdata     <= '0;
      lat_we    <= 1'b0;
      lat_stall <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else begin
      unique case (st)
        H_IDLE: if (strobe) begin
          lat_addr  <= addr;
          lat_wdata <= wdata;
          lat_we    <= ~wr_n;
          lat_stall <= disp_active;
          wait_n    <= ~disp_active;
          st        <= H_PEND;
        end
        H_PEND: if (acc_go) st <= H_CAPT;
        H_CAPT: begin
          if (!lat_we) rdata <= ram_q;
          st <= lat_stall ? H_HOLD : H_DONE;
        end
        H_HOLD: if (hs_rise) begin
          wait_n <= 1'b1;
          st     <= H_DONE;
        end
        H_DONE: if (!strobe) st <= H_IDLE;
        default: st <= H_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cyclesteal_vram_arb.sv
module cyclesteal_vram_arb #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hclk,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_wait_n,
  input  logic              disp_active,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_valid,
  output logic [DATA_W-1:0] fetch_data,
  output logic              slot_is_host
);

  logic              fetch_go;
  logic              hs_rise;
  logic              acc_go;
  logic              acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic              ram_en;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_q;

  csva_slot_timer u_slot (
    .clk          (clk),
    .rst          (rst),
    .slot_is_host (slot_is_host)
  );

  csva_edge_sync #(.STAGES(SYNC_STAGES)) u_hsync (
    .clk      (clk),
    .rst      (rst),
    .async_in (hclk),
    .rise     (hs_rise)
  );

  assign fetch_go = ~slot_is_host & disp_active;

  csva_host_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_host (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (host_cs_n),
    .rd_n        (host_rd_n),
    .wr_n        (host_wr_n),
    .addr        (host_addr),
    .wdata       (host_wdata),
    .disp_active (disp_active),
    .fetch_slot  (fetch_go),
    .hs_rise     (hs_rise),
    .ram_q       (ram_q),
    .acc_go      (acc_go),
    .acc_we      (acc_we),
    .acc_addr    (acc_addr),
    .acc_wdata   (acc_wdata),
    .wait_n      (host_wait_n),
    .rdata       (host_rdata)
  );

  assign ram_en   = fetch_go | acc_go;
  assign ram_we   = acc_go & acc_we;
  assign ram_addr = acc_go ? acc_addr : fetch_addr;

  csva_spram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ram_addr),
    .din  (acc_wdata),
    .dout (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) fetch_valid <= 1'b0;
    else     fetch_valid <= fetch_go;
  end

  assign fetch_data = ram_q;

endmodule

// File: rtl/csva_checks.sv
module csva_checks #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          slot_is_host,
  input logic          disp_active,
  input logic          fetch_valid,
  input logic          host_wait_n,
  input logic          hs_rise,
  input logic [DW-1:0] host_rdata,
  input logic          host_go,
  input logic          fetch_go
);

  // R2
  slot_alternate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> slot_is_host != $past(slot_is_host));

  // R3
  fetch_slot_only_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> $past(!slot_is_host && disp_active));

  // R5
  no_slot_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(host_go && fetch_go));

  // R6
  release_on_hclk_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_wait_n) |-> $past(hs_rise));

  // R7
  stall_only_display_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(host_wait_n) |-> $past(disp_active));

  // R8
  rdata_steady_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_wait_n) |-> $stable(host_rdata));

endmodule

bind cyclesteal_vram_arb csva_checks #(.DW(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .slot_is_host (slot_is_host),
  .disp_active  (disp_active),
  .fetch_valid  (fetch_valid),
  .host_wait_n  (host_wait_n),
  .hs_rise      (hs_rise),
  .host_rdata   (host_rdata),
  .host_go      (acc_go),
  .fetch_go     (fetch_go)
);

// File: tb/cyclesteal_vram_arb_test.sv
`timescale 1ns/1ps
module cyclesteal_vram_arb_test;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hclk = 1'b0;
  logic          host_cs_n = 1'b1;
  logic          host_rd_n = 1'b1;
  logic          host_wr_n = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          host_wait_n;
  logic          disp_active = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_valid;
  logic [DW-1:0] fetch_data;
  logic          slot_is_host;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cyclesteal_vram_arb #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .hclk(hclk),
    .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_wait_n(host_wait_n), .disp_active(disp_active),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
    .fetch_data(fetch_data), .slot_is_host(slot_is_host)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic release_strobes();
    host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
  endtask

  // R1, R2: reset state and slot alternation
  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 wait_n", host_wait_n, 1);
    check("R1 fetch_valid", fetch_valid, 0);
    check("R1 host_rdata", host_rdata, 0);
    check("R1 slot_is_host", slot_is_host, 1);
    @(negedge clk); check("R2 slot after 1 edge", slot_is_host, 0);
    @(negedge clk); check("R2 slot after 2 edges", slot_is_host, 1);
  endtask

  // R7: blanking write, wait never asserted
  task automatic blank_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_cs_n = 1'b0; host_wr_n = 1'b0; host_addr = a; host_wdata = d;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); check("R7 no wait on blank write", host_wait_n, 1);
    end
    release_strobes();
    @(negedge clk);
  endtask

  // R7, R5: blanking read, data after three edges
  task automatic blank_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    host_cs_n = 1'b0; host_rd_n = 1'b0; host_addr = a;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); check("R7 no wait on blank read", host_wait_n, 1);
    end
    check(tag, host_rdata, exp);
    release_strobes();
    @(negedge clk);
  endtask

  // R9: held strobe not taken twice
  task automatic t_held_strobe();
    @(negedge clk);
    host_cs_n = 1'b0; host_wr_n = 1'b0; host_addr = 8'h21; host_wdata = 16'hAAAA;
    repeat (4) @(negedge clk);
    host_wdata = 16'h5555;
    repeat (4) @(negedge clk);
    release_strobes();
    @(negedge clk);
    blank_read(8'h21, 16'hAAAA, "R9 held strobe not re-accepted");
  endtask

  // R10, R3: fetch behaviour
  task automatic t_fetch();
    int cnt = 0;
    disp_active = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); check("R10 no fetch in blanking", fetch_valid, 0);
    end
    disp_active = 1'b1; fetch_addr = 8'h10;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (fetch_valid) begin
        cnt++;
        check("R3 fetch data", fetch_data, 16'h1234);
      end
    end
    check("R3 fetch pulses in 6 cycles", cnt, 3);
  endtask

  // R4, R5, R6, R8: display-time read with stall
  task automatic t_disp_read();
    int cnt = 0;
    @(negedge clk);
    host_cs_n = 1'b0; host_rd_n = 1'b0; host_addr = 8'h30;
    @(negedge clk); check("R4 wait low one edge after request", host_wait_n, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R6 no release without hclk", host_wait_n, 0);
      if (fetch_valid) begin
        cnt++;
        check("R5 fetch undisturbed by host", fetch_data, 16'h1234);
      end
    end
    check("R5 fetches continue during host access", cnt >= 3, 1);
    check("R5 host read in host slot", host_rdata, 16'hBEEF);
    hclk = 1'b1;
    @(negedge clk); check("R6 wait after 1 edge", host_wait_n, 0);
    @(negedge clk); check("R6 wait after 2 edges", host_wait_n, 0);
    @(negedge clk); check("R6 wait after 3 edges", host_wait_n, 1);
    check("R8 rdata held at release", host_rdata, 16'hBEEF);
    release_strobes();
    hclk = 1'b0;
    @(negedge clk);
  endtask

  // R4, R5, R8: display-time write with stall
  task automatic t_disp_write();
    @(negedge clk);
    host_cs_n = 1'b0; host_wr_n = 1'b0; host_addr = 8'h40; host_wdata = 16'hC0DE;
    @(negedge clk); check("R4 wait low on display write", host_wait_n, 0);
    repeat (5) @(negedge clk);
    hclk = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 write released after hclk", host_wait_n, 1);
    check("R8 write leaves rdata", host_rdata, 16'hBEEF);
    release_strobes();
    hclk = 1'b0;
    @(negedge clk);
    disp_active = 1'b0;
    repeat (2) @(negedge clk);
    blank_read(8'h40, 16'hC0DE, "R5 display write stored");
  endtask

  initial begin
    t_reset();
    blank_write(8'h10, 16'h1234);
    blank_write(8'h30, 16'hBEEF);
    blank_read(8'h10, 16'h1234, "R7 blank read data");
    blank_write(8'h11, 16'h0F0F);
    check("R8 rdata unchanged by write", host_rdata, 16'h1234);
    t_held_strobe();
    t_fetch();
    t_disp_read();
    t_disp_write();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    finished = 1;
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule